// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable behavioural model of a 64-word by 16-bit serial EEPROM that sits on a three-wire bus. The bus has a chip select, a shift clock, a data input and a data output with an enable. The chip select, shift clock and data input are sampled in the clock domain of the block. A rising shift-clock edge is recognised by comparing two consecutive samples. The word array is held in registers. Programming is gated by an enable latch, and a self-timed programming cycle runs from a clock-cycle counter.

A host opens each transaction by raising chip select. It then shifts a start bit of 1, a two-bit operation code and a six-bit word address, most significant bit first. Write-type commands append sixteen data bits. When the host lowers chip select, the data output is released.

A host that raises chip select again while a programming cycle is still running sees the ready/busy state on the data output. A host that reconnects only after the cycle has finished sees no status.

Top module: `eep_serial_mem`

## Requirements
- R1: After reset, programming is disabled, `dout_oe` is 0, and every word reads as 16'hFFFF.
- R2: While chip select is low, `dout_oe` is 0 from the second clock after chip select falls. A partially shifted instruction is dropped when chip select falls.
- R3: Zeros shifted before the first 1 are ignored. That 1 is the start bit. The next 2 bits are the operation code and the 6 bits after that are the address, all MSB first.
- R4: Operation code 10 reads a word. On the shift-clock rise that carries the last address bit, the output drives a 0. The next 16 rises present the word MSB first, and every rise after that drives 0.
- R5: A read returns the stored word whether programming is enabled or disabled.
- R6: While programming is disabled, the single-word erase, single-word write, erase-all and write-all commands leave the array unchanged.
- R7: Operation code 00 with address bits [5:4] = 11 enables programming. The enable holds across transactions until operation code 00 with address bits [5:4] = 00 disables it. Address bits [3:0] are don't-care.
- R8: Operation code 01 stores the 16 data bits that follow the address into the addressed word. The programming cycle starts after the last data bit and lasts PROG_CYCLES clocks.
- R9: Operation code 11 sets every bit of the addressed word to 1.
- R10: Operation code 00 with address bits [5:4] = 10 sets every word to 16'hFFFF. Operation code 00 with address bits [5:4] = 01, followed by 16 data bits, stores that pattern into every word.
- R11: When chip select rises while a programming cycle runs, `dout_oe` becomes 1. `dout` shows 0 while busy and 1 once ready, until chip select falls. When chip select rises after the cycle has ended, `dout_oe` stays 0.
- R12: Instructions shifted during a busy-status session do not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock; rising edges move bits |
| di | input | 1 | Serial data input |
| dout | output | 1 | Serial data output value |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |

## Verification
The bench builds the block with PROG_CYCLES = 40 and the default 6-bit address and 16-bit word. With that short cycle, a busy-status probe fits inside the cycle while the shift clock runs at eight system clocks per bit. The cycle then completes within the same chip-select session, so the busy-to-ready change is observed. The default geometry keeps the top address, 63, and the whole-array commands over all 64 words within reach.

// File: rtl/eep_pkg.sv
// Package: shared encodings for the three-wire serial EEPROM model.
// Assumes: two-bit operation code followed by a word address, MSB first.
package eep_pkg;

    // Operation code carried right after the start bit
    typedef enum logic [1:0] {
        OPC_SPECIAL = 2'b00,
        OPC_WRITE   = 2'b01,
        OPC_READ    = 2'b10,
        OPC_ERASE   = 2'b11
    } opc_e;

    // Sub-command in the top two address bits when the operation code is 00
    typedef enum logic [1:0] {
        SUB_LOCK    = 2'b00,
        SUB_FILLALL = 2'b01,
        SUB_WIPEALL = 2'b10,
        SUB_UNLOCK  = 2'b11
    } sub_e;

    // Kind of work handed to the programming engine
    typedef enum logic [1:0] {
        PG_WORD_WR = 2'b00,
        PG_WORD_ER = 2'b01,
        PG_ALL_WR  = 2'b10,
        PG_ALL_ER  = 2'b11
    } pg_op_e;

    // Serial front-end state
    typedef enum logic [2:0] {
        FS_WAIT_START,
        FS_HEADER,
        FS_DATA,
        FS_READOUT,
        FS_STATUS,
        FS_DRAIN
    } fe_state_e;

endpackage

// File: rtl/eep_pin_sample.sv
// Module: eep_pin_sample
// Registers the three bus inputs once and derives rising-edge strobes.
// Assumes: the bus changes slowly relative to clk (several clk per shift bit),
// so a single sampling stage and a one-cycle edge strobe are enough.
module eep_pin_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_lvl,
    output logic cs_rise,
    output logic sk_rise,
    output logic di_lvl
);

    logic cs_prev;
    logic sk_lvl;
    logic sk_prev;

    // Sample the pins and keep the previous sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_lvl  <= 1'b0;
            cs_prev <= 1'b0;
            sk_lvl  <= 1'b0;
            sk_prev <= 1'b0;
            di_lvl  <= 1'b0;
        end else begin
            cs_lvl  <= cs;
            cs_prev <= cs_lvl;
            sk_lvl  <= sk;
            sk_prev <= sk_lvl;
            di_lvl  <= di;
        end
    end

    // Edge strobes last one clock
    assign cs_rise = cs_lvl & ~cs_prev;
    assign sk_rise = sk_lvl & ~sk_prev;

endmodule

// File: rtl/eep_prog_engine.sv
// Module: eep_prog_engine
// Holds the word array and performs self-timed programming.
// Assumes: a start request is only issued while not busy; the array update
// is committed at the end of the cycle of PROG_CYCLES clocks.
module eep_prog_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_start,
    input  pg_op_e            pg_op,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [DATA_W-1:0] pg_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              busy
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PROG_CYCLES - 1);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic [DATA_W-1:0] mem [DEPTH];
    logic [TMR_W-1:0]  tmr;
    pg_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              commit;

    assign commit  = busy && (tmr == TMR_LAST);
    assign rd_word = mem[rd_addr];

    // Latch the request and run the programming timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            tmr    <= '0;
            op_q   <= PG_WORD_WR;
            addr_q <= '0;
            data_q <= '0;
        end else if (busy) begin
            if (commit) begin
                busy <= 1'b0;
                tmr  <= '0;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end else if (pg_start) begin
            busy   <= 1'b1;
            tmr    <= '0;
            op_q   <= pg_op;
            addr_q <= pg_addr;
            data_q <= pg_data;
        end
    end

    // Update the addressed word or every word when the cycle completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem[w] <= ALL_ONES;
            end
        end else if (commit) begin
            for (int w = 0; w < DEPTH; w++) begin
                unique case (op_q)
                    PG_WORD_WR: if (addr_q == ADDR_W'(w)) mem[w] <= data_q;
                    PG_WORD_ER: if (addr_q == ADDR_W'(w)) mem[w] <= ALL_ONES;
                    PG_ALL_WR:  mem[w] <= data_q;
                    PG_ALL_ER:  mem[w] <= ALL_ONES;
                endcase
            end
        end
    end

    // R8: the timer never passes the programmed length
    a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tmr <= TMR_LAST));

    // R8: the cycle ends only after the full count
    a_r8_full_span: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tmr) == TMR_LAST));

    // R9: a finished word erase leaves the word all ones
    a_r9_word_erased: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == PG_WORD_ER) |-> (mem[addr_q] == ALL_ONES));

    // R8: a finished word write leaves the latched pattern in place
    a_r8_word_written: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_q == PG_WORD_WR) |-> (mem[addr_q] == data_q));

endmodule

// File: rtl/eep_cmd_frontend.sv
// Module: eep_cmd_frontend
// Shifts in instructions, decodes them, keeps the programming enable
// latch and drives the serial output (read data or ready/busy).
// Assumes: strobes from eep_pin_sample; one bit per sk_rise.
module eep_cmd_frontend
    import eep_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_rise,
    input  logic              sk_rise,
    input  logic              di_lvl,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              pg_start,
    output pg_op_e            pg_op,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [DATA_W-1:0] pg_data,
    output logic              dout,
    output logic              dout_oe
);

    localparam int HDR_W = 2 + ADDR_W;
    localparam int CNT_W = $clog2(HDR_W + DATA_W);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    fe_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-2:0]  hdr_q;
    logic [HDR_W-1:0]  hdr_full;
    logic [DATA_W-2:0] data_q;
    logic [DATA_W-1:0] data_full;
    logic [DATA_W-1:0] rd_sh;
    logic              wen;
    opc_e              opc;
    sub_e              sub;
    logic [ADDR_W-1:0] adr;
    logic              hdr_done;

    // Header and data words including the bit arriving now
    assign hdr_full  = {hdr_q, di_lvl};
    assign data_full = {data_q, di_lvl};
    assign opc       = opc_e'(hdr_full[HDR_W-1 -: 2]);
    assign adr       = hdr_full[ADDR_W-1:0];
    assign sub       = sub_e'(adr[ADDR_W-1 -: 2]);
    assign rd_addr   = adr;
    assign hdr_done  = (st == FS_HEADER) && sk_rise && (cnt == HDR_LAST);

    // Serial protocol state machine, enable latch and output driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FS_WAIT_START;
            cnt      <= '0;
            hdr_q    <= '0;
            data_q   <= '0;
            rd_sh    <= '0;
            wen      <= 1'b0;
            pg_start <= 1'b0;
            pg_op    <= PG_WORD_WR;
            pg_addr  <= '0;
            pg_data  <= '0;
            dout     <= 1'b0;
            dout_oe  <= 1'b0;
        end else begin
            pg_start <= 1'b0;
            if (!cs_lvl) begin
                st      <= FS_WAIT_START;
                cnt     <= '0;
                dout    <= 1'b0;
                dout_oe <= 1'b0;
            end else if (cs_rise) begin
                cnt <= '0;
                if (busy) begin
                    st      <= FS_STATUS;
                    dout    <= 1'b0;
                    dout_oe <= 1'b1;
                end else begin
                    st <= FS_WAIT_START;
                end
            end else begin
                unique case (st)
                    FS_WAIT_START: begin
                        if (sk_rise && di_lvl) begin
                            st  <= FS_HEADER;
                            cnt <= '0;
                        end
                    end
                    FS_HEADER: begin
                        if (sk_rise) begin
                            hdr_q <= hdr_full[HDR_W-2:0];
                            if (cnt != HDR_LAST) begin
                                cnt <= cnt + 1'b1;
                            end else begin
                                cnt     <= '0;
                                pg_addr <= adr;
                                st      <= FS_DRAIN;
                                unique case (opc)
                                    OPC_READ: begin
                                        rd_sh   <= rd_word;
                                        dout    <= 1'b0;
                                        dout_oe <= 1'b1;
                                        st      <= FS_READOUT;
                                    end
                                    OPC_WRITE: begin
                                        pg_op <= PG_WORD_WR;
                                        st    <= FS_DATA;
                                    end
                                    OPC_ERASE: begin
                                        pg_op    <= PG_WORD_ER;
                                        pg_start <= wen && !busy;
                                    end
                                    OPC_SPECIAL: begin
                                        unique case (sub)
                                            SUB_UNLOCK: wen <= 1'b1;
                                            SUB_LOCK:   wen <= 1'b0;
                                            SUB_WIPEALL: begin
                                                pg_op    <= PG_ALL_ER;
                                                pg_start <= wen && !busy;
                                            end
                                            SUB_FILLALL: begin
                                                pg_op <= PG_ALL_WR;
                                                st    <= FS_DATA;
                                            end
                                        endcase
                                    end
                                endcase
                            end
                        end
                    end
                    FS_DATA: begin
                        if (sk_rise) begin
                            data_q <= data_full[DATA_W-2:0];
                            if (cnt != DATA_LAST) begin
                                cnt <= cnt + 1'b1;
                            end else begin
                                cnt      <= '0;
                                pg_data  <= data_full;
                                pg_start <= wen && !busy;
                                st       <= FS_DRAIN;
                            end
                        end
                    end
                    FS_READOUT: begin
                        if (sk_rise) begin
                            dout  <= rd_sh[DATA_W-1];
                            rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    FS_STATUS: begin
                        dout <= !busy;
                    end
                    FS_DRAIN: begin
                    end
                    default: st <= FS_WAIT_START;
                endcase
            end
        end
    end

    // R2: the output is released once chip select is seen low
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |=> !dout_oe);

    // R6: no programming request leaves while the enable latch was clear
    a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
        pg_start |-> $past(wen));

    // R12: the engine is never asked to start while busy
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        pg_start |-> !busy);

    // R4: a decoded read drives the leading zero at once
    a_r4_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && !cs_rise && hdr_done && opc == OPC_READ) |=> (dout_oe && !dout));

    // R11: a status session shows ready once the engine is idle
    a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FS_STATUS && cs_lvl && !busy) |=> (dout && dout_oe));

endmodule

// File: rtl/eep_serial_mem.sv
// Module: eep_serial_mem (top)
// Three-wire serial EEPROM model: pin sampling, command front end and
// programming engine with register-held word array.
// Assumes: clk runs several times faster than sk; supply always valid.
module eep_serial_mem
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);

    logic              cs_lvl;
    logic              cs_rise;
    logic              sk_rise;
    logic              di_lvl;
    logic              busy;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              pg_start;
    pg_op_e            pg_op;
    logic [ADDR_W-1:0] pg_addr;
    logic [DATA_W-1:0] pg_data;

    eep_pin_sample u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .cs_lvl  (cs_lvl),
        .cs_rise (cs_rise),
        .sk_rise (sk_rise),
        .di_lvl  (di_lvl)
    );

    eep_cmd_frontend #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl   (cs_lvl),
        .cs_rise  (cs_rise),
        .sk_rise  (sk_rise),
        .di_lvl   (di_lvl),
        .busy     (busy),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .pg_start (pg_start),
        .pg_op    (pg_op),
        .pg_addr  (pg_addr),
        .pg_data  (pg_data),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    eep_prog_engine #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_start (pg_start),
        .pg_op    (pg_op),
        .pg_addr  (pg_addr),
        .pg_data  (pg_data),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word),
        .busy     (busy)
    );

    // R1: nothing is driven out during reset recovery
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !dout_oe);

endmodule

// File: tb/eep_serial_mem_test.sv
module eep_serial_mem_test;

    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout;
    logic dout_oe;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [15:0] mdl [64];
    bit          mdl_wen = 1'b0;

    logic [17:0] exp_q [$];
    string       tag_q [$];
    logic [17:0] got_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    eep_serial_mem #(
        .ADDR_W      (6),
        .DATA_W      (16),
        .PROG_CYCLES (PROG)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares captured read frames against the expected queue
    initial begin
        forever begin
            @(posedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [17:0] g;
                logic [17:0] e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(g), 32'(e));
            end
        end
    end

    task automatic sk_bit(input logic b, output logic o, output logic oe);
        @(negedge clk);
        di = b;
        repeat (3) @(negedge clk);
        sk = 1'b1;
        repeat (4) @(negedge clk);
        o  = dout;
        oe = dout_oe;
        sk = 1'b0;
    endtask

    task automatic shift(input logic [31:0] v, input int n);
        logic o;
        logic oe;
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i], o, oe);
    endtask

    task automatic cs_open();
        @(negedge clk);
        cs = 1'b0;
        repeat (4) @(negedge clk);
        cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_close_wait();
        @(negedge clk);
        cs = 1'b0;
        repeat (PROG + 20) @(negedge clk);
    endtask

    // Driver: issue a read and queue the expected frame
    task automatic do_read(input logic [5:0] a, input string tag);
        logic [17:0] cap;
        logic o;
        logic oe;
        exp_q.push_back({1'b0, mdl[a], 1'b0});
        tag_q.push_back(tag);
        cs_open();
        shift({29'd0, 3'b110}, 3);
        shift({26'd0, a[5:1]}, 5);
        sk_bit(a[0], o, oe);
        cap[17] = o;
        for (int i = 16; i >= 0; i--) begin
            sk_bit(1'b0, o, oe);
            cap[i] = o;
        end
        got_q.push_back(cap);
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic do_special(input logic [1:0] sub);
        cs_open();
        shift({23'd0, 3'b100, sub, 4'b0000}, 9);
        if (sub == 2'b11) mdl_wen = 1'b1;
        if (sub == 2'b00) mdl_wen = 1'b0;
        if (sub == 2'b10 && mdl_wen) for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
        cs_close_wait();
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d, input bit leave_open);
        cs_open();
        shift({23'd0, 3'b101, a}, 9);
        shift({16'd0, d}, 16);
        if (mdl_wen) mdl[a] = d;
        if (!leave_open) cs_close_wait();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 dout_oe after reset", 32'(dout_oe), 32'd0);
        do_read(6'd0, "R1 erased after reset / R4 frame");

        // Locked: write ignored
        do_write(6'd3, 16'h1111, 1'b0);
        do_read(6'd3, "R6 write while locked");

        // Unlock and write
        do_special(2'b11);
        do_write(6'd3, 16'hA5C3, 1'b0);
        do_read(6'd3, "R8 word write R7 enable");

        // Leading zeros before start bit
        cs_open();
        shift(32'h0, 4);
        shift({23'd0, 3'b101, 6'd63}, 9);
        shift(32'h1234, 16);
        mdl[63] = 16'h1234;
        cs_close_wait();
        do_read(6'd63, "R3 leading zeros before start");

        // Partial instruction discarded, then a clean read
        cs_open();
        shift({27'd0, 5'b10111}, 5);
        @(negedge clk);
        cs = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 released with cs low", 32'(dout_oe), 32'd0);
        do_read(6'd3, "R2 partial dropped");

        // Status during a running cycle
        do_write(6'd10, 16'h0F0F, 1'b1);
        cs_open();
        check("R11 status enabled while busy", 32'(dout_oe), 32'd1);
        check("R11 busy shows 0", 32'(dout), 32'd0);
        shift({23'd0, 3'b101, 6'd11}, 9);
        shift(32'h0000, 16);
        check("R11 ready shows 1", 32'(dout), 32'd1);
        check("R11 still driven", 32'(dout_oe), 32'd1);
        @(negedge clk);
        cs = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 released on cs low", 32'(dout_oe), 32'd0);
        cs = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 no status after cycle", 32'(dout_oe), 32'd0);
        cs = 1'b0;
        do_read(6'd10, "R8 write committed");
        do_read(6'd11, "R12 write during busy ignored");

        // Single-word erase
        cs_open();
        shift({23'd0, 3'b111, 6'd3}, 9);
        mdl[3] = 16'hFFFF;
        cs_close_wait();
        do_read(6'd3, "R9 word erase");

        // Lock again: write ignored, read still works
        do_special(2'b00);
        do_write(6'd63, 16'hBEEF, 1'b0);
        do_read(6'd63, "R5 read while locked R7 lock holds");

        // Whole-array commands
        do_special(2'b11);
        cs_open();
        shift({23'd0, 3'b100, 2'b01, 4'b0000}, 9);
        shift(32'h5A5A, 16);
        for (int i = 0; i < 64; i++) mdl[i] = 16'h5A5A;
        cs_close_wait();
        do_read(6'd0, "R10 fill all word 0");
        do_read(6'd40, "R10 fill all word 40");
        do_special(2'b00);
        do_special(2'b10);
        do_read(6'd20, "R6 erase-all while locked");
        do_special(2'b11);
        do_special(2'b10);
        do_read(6'd7, "R10 erase all");

        wait (got_q.size() == 0);
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog act=%h exp=%h", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule